// File: doc/BRIEF.md
# Concurrent-Write Conflict Resolver

This block sits in front of one write port of a shared memory. Up to P processor ports may raise a write request in the same cycle, each with its own address and data word. The block picks one target address per cycle, gathers every requester aimed at that word into a group, and folds the group into at most one committed write. How the group is folded is set by a two-bit mode. In common mode, all values must agree. Arbitrary mode takes one member picked by a free-running pseudo-random register. Priority mode takes the lowest-numbered port. Sum mode writes the wrapped sum and flags any carry out. A separate exclusive-write input turns any group of more than one writer into a failure.

When requesters in one cycle aim at different addresses, the target is the address of the lowest-numbered valid port. Valid ports aimed elsewhere see their stall bit raised in the same cycle and are expected to hold their request; they are served in later cycles, one address per cycle. The result leaves through a registered controller with three states. ST_IDLE means no write. ST_WRITE raises the write enable with the latched address and data. ST_FAIL raises the conflict flag for that cycle. On every clock edge the next state is chosen from the current requests: ST_IDLE when no port is valid, ST_FAIL when the group is rejected, and ST_WRITE otherwise. Any state can move to any other. A small internal register file takes each committed write so that the checker can compare it.

Top module: `cwr_resolver`

## Requirements
- R1: During and right after reset, wr_en, conflict and overflow are 0.
- R2: Mode 0 (common): when all members of the group carry the same data, the next cycle shows wr_en=1 with that data and the target address.
- R3: Mode 0 (common): when the group's data values differ, the next cycle shows wr_en=0 and conflict=1. If the following cycle has no such mismatch, conflict returns to 0.
- R4: Mode 2 (priority): the committed data is that of the lowest-numbered port in the group. Port 0 has the highest priority.
- R5: Mode 1 (arbitrary): the write commits and its data equals the data of some member of the group.
- R6: Mode 3 (sum): the committed data is the group's data sum modulo 2^W. overflow=1 in that same cycle exactly when the true sum exceeds 2^W-1. Outside sum mode, overflow stays 0.
- R7: With excl_en=1, the mode is ignored. A group of one writer commits that writer's data. A group of two or more gives wr_en=0 and conflict=1.
- R8: The target address is the address of the lowest-numbered valid port. In the same cycle, stall[i]=1 exactly for valid ports whose address differs from the target. Port 0 is never stalled.
- R9: Outputs follow the requests of the previous cycle after one register stage. A cycle with no valid port gives wr_en=0 and conflict=0 in the next cycle. Every commit is stored in the internal register file.
- R10: wr_en and conflict are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | P | Per-port write request |
| req_data | input | P*W | Per-port data, port i in bits [i*W +: W] |
| req_addr | input | P*AW | Per-port address, port i in bits [i*AW +: AW] |
| mode | input | 2 | 0 common, 1 arbitrary, 2 priority, 3 sum |
| excl_en | input | 1 | Exclusive-write regime |
| stall | output | P | Port valid but aimed at a non-target address this cycle |
| wr_en | output | 1 | Committed write this cycle |
| wr_addr | output | AW | Address of the committed write |
| wr_data | output | W | Data of the committed write |
| conflict | output | 1 | Group rejected (common mismatch or exclusive violation) |
| overflow | output | 1 | Carry out of the sum-mode write |

## Verification
The assertions rely on two assumptions. First, mode and excl_en are stable across the cycle in which a request is sampled. Second, a port whose request arrives while reset is active is not expected to commit. The priority and idle properties therefore qualify their antecedents on the previous cycle being out of reset. The stimulus changes inputs only just after the falling edge and holds them at 0 during reset. In the directed multi-address sequences, the bench drops the request of each served port and keeps every stalled one unchanged, as a real requester would. The random phase keeps addresses within a small range so that groups of several writers occur often.

// File: rtl/cwr_pkg.sv
package cwr_pkg;

    typedef enum logic [1:0] {
        MODE_COMMON = 2'd0,
        MODE_ARBIT  = 2'd1,
        MODE_PRIO   = 2'd2,
        MODE_SUM    = 2'd3
    } cwr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_FAIL  = 2'd2
    } cwr_state_e;

endpackage

// File: rtl/cwr_target_sel.sv
module cwr_target_sel #(
    parameter int P  = 4,
    parameter int AW = 3,
    localparam int IW = (P > 1) ? $clog2(P) : 1
) (
    input  logic [P-1:0]    req_valid,
    input  logic [P*AW-1:0] req_addr,
    output logic [AW-1:0]   tgt_addr,
    output logic [IW-1:0]   lead_idx,
    output logic            any_req,
    output logic [P-1:0]    grp_mask,
    output logic [P-1:0]    stall
);

    // lowest-numbered valid port sets the target for this cycle
    always_comb begin
        any_req  = 1'b0;
        lead_idx = '0;
        tgt_addr = '0;
        for (int i = 0; i < P; i++) begin
            if (req_valid[i] && !any_req) begin
                any_req  = 1'b1;
                lead_idx = IW'(i);
                tgt_addr = req_addr[i*AW +: AW];
            end
        end
    end

    generate
        for (genvar g = 0; g < P; g++) begin : g_port
            assign grp_mask[g] = req_valid[g] && (req_addr[g*AW +: AW] == tgt_addr);
            assign stall[g]    = req_valid[g] && !grp_mask[g];
        end
    endgenerate

endmodule

// File: rtl/cwr_lfsr.sv
module cwr_lfsr #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [LW-1:0] state
);

    logic fb;

    // taps for an 8-bit maximal sequence; other widths still cycle
    always_comb begin
        if (LW >= 8) fb = state[LW-1] ^ state[LW-3] ^ state[LW-4] ^ state[LW-5];
        else         fb = state[LW-1] ^ state[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LW'(1);
        else        state <= {state[LW-2:0], fb};
    end

endmodule

// File: rtl/cwr_combine.sv
module cwr_combine
    import cwr_pkg::*;
#(
    parameter int P  = 4,
    parameter int W  = 8,
    parameter int LW = 8,
    localparam int IW = (P > 1) ? $clog2(P) : 1,
    localparam int SW = W + IW
) (
    input  logic [P-1:0]   grp_mask,
    input  logic [P*W-1:0] req_data,
    input  logic [IW-1:0]  lead_idx,
    input  logic [LW-1:0]  rnd,
    input  cwr_mode_e      mode,
    input  logic           excl_en,
    output logic [W-1:0]   res_data,
    output logic           res_fail,
    output logic           res_ovf
);

    logic [W-1:0]  lead_data;
    logic [IW:0]   grp_cnt;
    logic          all_match;
    logic [SW-1:0] acc;
    logic [IW-1:0] pick;
    logic          got;
    int            start;
    int            j;

    assign lead_data = req_data[lead_idx*W +: W];

    always_comb begin
        grp_cnt   = '0;
        all_match = 1'b1;
        acc       = '0;
        for (int i = 0; i < P; i++) begin
            if (grp_mask[i]) begin
                grp_cnt = grp_cnt + 1'b1;
                acc     = acc + {{(SW-W){1'b0}}, req_data[i*W +: W]};
                if (req_data[i*W +: W] != lead_data) all_match = 1'b0;
            end
        end
    end

    // rotating scan from a pseudo-random start: always lands on a member
    always_comb begin
        start = int'(rnd) % P;
        got   = 1'b0;
        pick  = lead_idx;
        j     = 0;
        for (int k = 0; k < P; k++) begin
            j = (start + k) % P;
            if (grp_mask[j] && !got) begin
                got  = 1'b1;
                pick = IW'(j);
            end
        end
    end

    always_comb begin
        res_data = lead_data;
        res_fail = 1'b0;
        res_ovf  = 1'b0;
        if (excl_en) begin
            res_fail = (grp_cnt > 1);
        end else begin
            unique case (mode)
                MODE_COMMON: res_fail = !all_match;
                MODE_ARBIT:  res_data = req_data[pick*W +: W];
                MODE_PRIO:   res_data = lead_data;
                MODE_SUM: begin
                    res_data = acc[W-1:0];
                    res_ovf  = |acc[SW-1:W];
                end
                default:     res_data = lead_data;
            endcase
        end
    end

endmodule

// File: rtl/cwr_resolver.sv
module cwr_resolver
    import cwr_pkg::*;
#(
    parameter int P  = 4,
    parameter int W  = 8,
    parameter int AW = 3,
    parameter int LW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [P-1:0]    req_valid,
    input  logic [P*W-1:0]  req_data,
    input  logic [P*AW-1:0] req_addr,
    input  logic [1:0]      mode,
    input  logic            excl_en,
    output logic [P-1:0]    stall,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [W-1:0]    wr_data,
    output logic            conflict,
    output logic            overflow
);

    localparam int IW    = (P > 1) ? $clog2(P) : 1;
    localparam int DEPTH = 1 << AW;

    logic [AW-1:0] tgt_addr;
    logic [IW-1:0] lead_idx;
    logic          any_req;
    logic [P-1:0]  grp_mask;
    logic [LW-1:0] rnd;
    logic [W-1:0]  res_data;
    logic          res_fail;
    logic          res_ovf;

    cwr_state_e state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [W-1:0]  data_q;
    logic          ovf_q;
    logic [DEPTH-1:0][W-1:0] mem_q;

    cwr_target_sel #(.P(P), .AW(AW)) sel_i (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .tgt_addr  (tgt_addr),
        .lead_idx  (lead_idx),
        .any_req   (any_req),
        .grp_mask  (grp_mask),
        .stall     (stall)
    );

    cwr_lfsr #(.LW(LW)) lfsr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .state (rnd)
    );

    cwr_combine #(.P(P), .W(W), .LW(LW)) comb_i (
        .grp_mask (grp_mask),
        .req_data (req_data),
        .lead_idx (lead_idx),
        .rnd      (rnd),
        .mode     (cwr_mode_e'(mode)),
        .excl_en  (excl_en),
        .res_data (res_data),
        .res_fail (res_fail),
        .res_ovf  (res_ovf)
    );

    // next-state selection
    always_comb begin
        if (!any_req)      state_d = ST_IDLE;
        else if (res_fail) state_d = ST_FAIL;
        else               state_d = ST_WRITE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // commit data path and checking register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            ovf_q  <= 1'b0;
            mem_q  <= '0;
        end else if (state_d == ST_WRITE) begin
            addr_q          <= tgt_addr;
            data_q          <= res_data;
            ovf_q           <= res_ovf;
            mem_q[tgt_addr] <= res_data;
        end
    end

    // outputs from state
    always_comb begin
        wr_addr = addr_q;
        wr_data = data_q;
        unique case (state_q)
            ST_IDLE: begin
                wr_en    = 1'b0;
                conflict = 1'b0;
                overflow = 1'b0;
            end
            ST_WRITE: begin
                wr_en    = 1'b1;
                conflict = 1'b0;
                overflow = ovf_q;
            end
            ST_FAIL: begin
                wr_en    = 1'b0;
                conflict = 1'b1;
                overflow = 1'b0;
            end
            default: begin
                wr_en    = 1'b0;
                conflict = 1'b0;
                overflow = 1'b0;
            end
        endcase
    end

endmodule

module cwr_resolver_chk #(
    parameter int P  = 4,
    parameter int W  = 8,
    parameter int AW = 3,
    localparam int DEPTH = 1 << AW
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [P-1:0]            req_valid,
    input logic [W-1:0]            data0,
    input logic [AW-1:0]           addr0,
    input logic [1:0]              mode,
    input logic                    excl_en,
    input logic [P-1:0]            stall,
    input logic                    wr_en,
    input logic [AW-1:0]           wr_addr,
    input logic [W-1:0]            wr_data,
    input logic                    conflict,
    input logic                    overflow,
    input logic [DEPTH-1:0][W-1:0] mem_q
);

    assert_no_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !conflict);

    assert_ovf_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> wr_en);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(req_valid) == '0)) |-> (!wr_en && !conflict));

    assert_prio_port0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid[0]) && ($past(mode) == 2'd2) && !$past(excl_en))
        |-> (wr_en && (wr_data == $past(data0)) && (wr_addr == $past(addr0))));

    assert_stall_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall & ~req_valid) == '0);

    assert_progress_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid != '0) |-> ((req_valid & ~stall) != '0));

    assert_port0_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stall[0]);

    assert_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (mem_q[wr_addr] == wr_data));

endmodule

bind cwr_resolver cwr_resolver_chk #(.P(P), .W(W), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .data0     (req_data[W-1:0]),
    .addr0     (req_addr[AW-1:0]),
    .mode      (mode),
    .excl_en   (excl_en),
    .stall     (stall),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .conflict  (conflict),
    .overflow  (overflow),
    .mem_q     (mem_q)
);

// File: tb/cwr_resolver_tb.sv
module cwr_resolver_tb_top;

    localparam int P  = 4;
    localparam int W  = 8;
    localparam int AW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [P-1:0]    v = '0;
    logic [W-1:0]    d [P];
    logic [AW-1:0]   a [P];
    logic [1:0]      mode_r = 2'd0;
    logic            excl_r = 1'b0;
    logic [P*W-1:0]  data_f;
    logic [P*AW-1:0] addr_f;
    logic [P-1:0]    stall;
    logic            wr_en, conflict, overflow;
    logic [AW-1:0]   wr_addr;
    logic [W-1:0]    wr_data;

    int checks = 0;
    int errors = 0;
    logic [P-1:0] last_grp;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < P; i++) begin
            data_f[i*W +: W]   = d[i];
            addr_f[i*AW +: AW] = a[i];
        end
    end

    cwr_resolver #(.P(P), .W(W), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(v), .req_data(data_f), .req_addr(addr_f),
        .mode(mode_r), .excl_en(excl_r), .stall(stall), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .conflict(conflict), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one clock: model the current request, check stall, then the registered result
    task automatic step();
        int lead = -1;
        int cnt = 0;
        int sum = 0;
        bit eq = 1;
        bit we = 0, cf = 0, ov = 0, member = 0;
        int ed = 0;
        logic [P-1:0] grp = '0;
        string tag = "R9";
        for (int i = 0; i < P; i++) if (v[i] && lead < 0) lead = i;
        if (lead >= 0) begin
            for (int i = 0; i < P; i++) begin
                if (v[i] && a[i] == a[lead]) begin
                    grp[i] = 1'b1;
                    cnt++;
                    sum += int'(d[i]);
                    if (d[i] != d[lead]) eq = 0;
                end
            end
            if (excl_r) begin
                tag = "R7";
                if (cnt > 1) cf = 1;
                else begin we = 1; ed = int'(d[lead]); end
            end else begin
                case (mode_r)
                    2'd0: begin
                        tag = eq ? "R2" : "R3";
                        if (eq) begin we = 1; ed = int'(d[lead]); end
                        else cf = 1;
                    end
                    2'd1: begin tag = "R5"; we = 1; end
                    2'd2: begin tag = "R4"; we = 1; ed = int'(d[lead]); end
                    default: begin
                        tag = "R6"; we = 1; ed = sum % (1 << W); ov = (sum >= (1 << W));
                    end
                endcase
            end
        end
        last_grp = grp;
        #1;
        chk(stall == (v & ~grp), "R8", "stall", int'(stall), int'(v & ~grp));
        @(posedge clk);
        @(negedge clk);
        chk(wr_en == we, tag, "wr_en", int'(wr_en), int'(we));
        chk(conflict == cf, tag, "conflict", int'(conflict), int'(cf));
        chk(overflow == ov, (tag == "R6") ? "R6" : tag, "overflow", int'(overflow), int'(ov));
        chk(!(wr_en && conflict), "R10", "wr_en&conflict", int'(wr_en && conflict), 0);
        if (we && lead >= 0) begin
            chk(wr_addr == a[lead], tag, "wr_addr", int'(wr_addr), int'(a[lead]));
            if (tag == "R5") begin
                for (int i = 0; i < P; i++) if (grp[i] && d[i] == wr_data) member = 1;
                chk(member, "R5", "wr_data member", int'(wr_data), int'(d[lead]));
            end else begin
                chk(int'(wr_data) == ed, tag, "wr_data", int'(wr_data), ed);
            end
        end
    endtask

    task automatic set_all(input logic [P-1:0] vv, input logic [1:0] m, input logic ex,
                           input int d0, input int d1, input int d2, input int d3,
                           input int a0, input int a1, input int a2, input int a3);
        v = vv; mode_r = m; excl_r = ex;
        d[0] = W'(d0); d[1] = W'(d1); d[2] = W'(d2); d[3] = W'(d3);
        a[0] = AW'(a0); a[1] = AW'(a1); a[2] = AW'(a2); a[3] = AW'(a3);
    endtask

    // serve a multi-address batch: served ports drop, stalled ports hold
    task automatic drain();
        for (int n = 0; n < P && v != '0; n++) begin
            step();
            v = v & ~last_grp;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < P; i++) begin d[i] = '0; a[i] = '0; end
        repeat (3) @(negedge clk);
        chk(!wr_en && !conflict && !overflow, "R1", "outputs in reset",
            int'({wr_en, conflict, overflow}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_en && !conflict && !overflow, "R1", "outputs after reset",
            int'({wr_en, conflict, overflow}), 0);

        v = '0; step();                                            // R9 idle
        set_all(4'b1111, 2'd0, 0, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 2, 2, 2, 2); step(); // R2
        set_all(4'b0110, 2'd0, 0, 0, 8'h33, 8'h33, 0, 0, 6, 6, 0); step();         // R2
        set_all(4'b1011, 2'd0, 0, 8'h11, 8'h11, 0, 8'h12, 4, 4, 0, 4); step();    // R3
        v = '0; step();
        chk(!conflict, "R3", "conflict pulse ended", int'(conflict), 0);

        for (int r = 0; r < 8; r++) begin                          // R5
            set_all(4'b1111, 2'd1, 0, 8'h10 + r, 8'h20 + r, 8'h30 + r, 8'h40 + r, 1, 1, 1, 1);
            step();
        end
        set_all(4'b1110, 2'd2, 0, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 5, 5, 5, 5); step(); // R4 port1
        set_all(4'b1111, 2'd2, 0, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 5, 5, 5, 5); step(); // R4 port0
        set_all(4'b1111, 2'd3, 0, 1, 2, 3, 4, 7, 7, 7, 7); step();                 // R6 10
        set_all(4'b1111, 2'd3, 0, 8'h80, 8'h90, 8'h7F, 8'h01, 3, 3, 3, 3); step(); // R6 carry
        set_all(4'b0011, 2'd3, 0, 8'hFF, 8'h01, 0, 0, 0, 0, 0, 0); step();         // R6 wrap to 0
        set_all(4'b0100, 2'd3, 0, 0, 0, 8'hFF, 0, 0, 0, 1, 0); step();             // R6 no carry
        set_all(4'b0100, 2'd0, 1, 0, 0, 8'h77, 0, 0, 0, 6, 0); step();             // R7 single
        set_all(4'b1100, 2'd2, 1, 0, 0, 8'h01, 8'h02, 0, 0, 3, 3); step();         // R7 double
        set_all(4'b1001, 2'd3, 1, 8'h09, 0, 0, 8'h09, 2, 0, 0, 5); drain();        // R7 + R8

        set_all(4'b1111, 2'd2, 0, 8'hA0, 8'hA1, 8'hA2, 8'hA3, 3, 1, 3, 5); drain(); // R8
        set_all(4'b1110, 2'd3, 0, 0, 8'hF0, 8'h20, 8'h0F, 0, 4, 2, 4); drain();     // R8 sum
        set_all(4'b1111, 2'd0, 0, 8'h44, 8'h44, 8'h45, 8'h44, 0, 1, 1, 0); drain(); // R8 common

        for (int r = 0; r < 300; r++) begin
            v = P'($urandom);
            mode_r = 2'($urandom);
            excl_r = (($urandom % 8) == 0);
            for (int i = 0; i < P; i++) begin
                d[i] = W'($urandom % 4) + 8'hF0;
                a[i] = AW'($urandom % 3);
            end
            step();
        end

        v = '0;
        step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule